// File: doc/BRIEF.md
# Register Move and Swap Sequencer

This block holds the programmer-visible registers of a small 8/16-bit accumulator machine and carries out register-to-register copy (TFR) and register swap (EXG) operations as a multi-cycle state machine. A one-cycle `start` strobe launches an operation. `op_exg` picks a swap over a copy, and `postbyte` names the two registers involved. Every move passes over a single 16-bit path and through an internal 16-bit holding register, on fixed pairs of cycles. Because of this, a byte copy costs exactly as much as a word copy.

The sequencer states are:

- `S_IDLE`: waiting for work.
- `S_OPC` and `S_PBY`: cycles 1 and 2, the opcode and postbyte slots.
- `S_P1A` and `S_P1B`: cycles 3 and 4. The first-named register is loaded into the holding register at the end of `S_P1B`.
- `S_P2A` and `S_P2B`: cycles 5 and 6. At the end of `S_P2B`, TFR writes the holding register to the destination. EXG instead writes the second register straight into the first.
- `S_P3A` and `S_P3B`: cycles 7 and 8, used by EXG only. The holding register is written to the second register at the end of `S_P3B`.
- `S_FIN`: the one-cycle completion slot.

The transitions are:

- `S_IDLE` and `S_FIN` go to `S_OPC` on `start`. Otherwise they go to `S_IDLE`.
- Each cycle state advances to the next one in order.
- `S_P2B` goes to `S_P3A` for EXG and to `S_FIN` for TFR.
- `S_P3B` goes to `S_FIN`.

Top module: `xfer_exchange_unit`

## Requirements
- R1: A synchronous reset clears every register to zero, returns the sequencer to `S_IDLE` and holds `busy` and `done` low.
- R2: `postbyte[7:4]` names the source (first) register and `postbyte[3:0]` names the destination (second) register. The register codes are: 0 = D, 1 = X, 2 = Y, 3 = U, 4 = S, 5 = PC, 8 = A, 9 = B, 10 = CC, 11 = DP.
- R3: TFR (`op_exg` = 0) copies the source into the destination. Counting the clock edge that samples `start` as edge k, the destination changes at edge k+6. `busy` is high after edges k through k+5.
- R4: EXG (`op_exg` = 1) swaps the two registers. It completes at edge k+8, and `busy` is high after edges k through k+7.
- R5: Reading a byte register onto the 16-bit path yields 0xFF in the high byte and the register in the low byte. Writing a byte register keeps only the low byte. Byte-to-byte operations take the same number of cycles as word operations.
- R6: Reading D yields {A, B}. Writing D loads A with the high byte and B with the low byte.
- R7: Codes 6, 7 and 12 to 15 read as 0xFFFF, and writing them changes no register.
- R8: A `start` that arrives while `busy` is high is ignored and leaves the running operation and all registers as if it had not occurred.
- R9: `done` is high for exactly one cycle, right after the final write, while `busy` is low. A `start` in that same cycle is accepted and begins a new operation.
- R10: During EXG, the second register is written into the first before the held first value is written into the second. When the two registers overlap (for example D with A), the later write wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Launch strobe |
| op_exg | input | 1 | 1 = swap, 0 = copy |
| postbyte | input | 8 | Register pair select |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| reg_a | output | 8 | Accumulator A |
| reg_b | output | 8 | Accumulator B |
| reg_x | output | 16 | Index X |
| reg_y | output | 16 | Index Y |
| reg_u | output | 16 | User stack pointer |
| reg_s | output | 16 | System stack pointer |
| reg_pc | output | 16 | Program counter |
| reg_cc | output | 8 | Condition codes |
| reg_dp | output | 8 | Direct page |

## Verification
Two collisions are targeted. The first is a new `start` landing on the cycle in which `done` is high: the bench chains a second operation onto the completion slot. That operation must be taken, and both results must appear, each at its own predicted edge. The second is a `start` pulse arriving while `busy` is high. It carries a postbyte that would visibly overwrite S if it were obeyed. The scoreboard's register snapshot shows whether S stayed untouched, and the absence of an extra `done` shows that no second operation ran.

// File: rtl/xfer_pkg.sv
package xfer_pkg;
    localparam int WORD_W = 16;
    localparam int BYTE_W = 8;
    localparam int SEL_W  = 4;

    typedef enum logic [3:0] {
        S_IDLE, S_OPC, S_PBY,
        S_P1A, S_P1B,
        S_P2A, S_P2B,
        S_P3A, S_P3B,
        S_FIN
    } seq_state_t;
endpackage

// File: rtl/xfer_regfile.sv
module xfer_regfile #(
    parameter int WORD_W   = 16,
    parameter int BYTE_W   = 8,
    parameter int SEL_W    = 4,
    parameter int NUM_WIDE = 5,
    parameter int NUM_BYTE = 4,
    parameter int BYTE_BASE = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SEL_W-1:0]  rd_sel,
    output logic [WORD_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] wide_q [NUM_WIDE],
    output logic [BYTE_W-1:0] byte_q [NUM_BYTE]
);
    localparam int PAD_W = WORD_W - BYTE_W;

    // read mux: D composite, wide registers, padded byte registers
    always_comb begin
        rd_data = '1;
        if (rd_sel == '0) begin
            rd_data = {byte_q[0], byte_q[1]};
        end
        for (int g = 0; g < NUM_WIDE; g++) begin
            if (rd_sel == SEL_W'(g + 1)) rd_data = wide_q[g];
        end
        for (int g = 0; g < NUM_BYTE; g++) begin
            if (rd_sel == SEL_W'(BYTE_BASE + g)) rd_data = {{PAD_W{1'b1}}, byte_q[g]};
        end
    end

    genvar g;
    generate
        for (g = 0; g < NUM_WIDE; g++) begin : g_wide
            always_ff @(posedge clk) begin
                if (rst)                                   wide_q[g] <= '0;
                else if (wr_en && wr_sel == SEL_W'(g + 1)) wide_q[g] <= wr_data;
            end
        end
        for (g = 0; g < NUM_BYTE; g++) begin : g_byte
            if (g < 2) begin : g_dpart
                // A takes the high half of D, B the low half
                always_ff @(posedge clk) begin
                    if (rst) byte_q[g] <= '0;
                    else if (wr_en && wr_sel == '0)
                        byte_q[g] <= wr_data[WORD_W-1-g*BYTE_W -: BYTE_W];
                    else if (wr_en && wr_sel == SEL_W'(BYTE_BASE + g))
                        byte_q[g] <= wr_data[BYTE_W-1:0];
                end
            end else begin : g_plain
                always_ff @(posedge clk) begin
                    if (rst) byte_q[g] <= '0;
                    else if (wr_en && wr_sel == SEL_W'(BYTE_BASE + g))
                        byte_q[g] <= wr_data[BYTE_W-1:0];
                end
            end
        end
    endgenerate

    // R7
    bad_code_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel > SEL_W'(BYTE_BASE + NUM_BYTE - 1))
        |=> ($stable(wide_q[0]) && $stable(wide_q[NUM_WIDE-1]) && $stable(byte_q[0]) && $stable(byte_q[1])));
    // R6
    d_split_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == '0) |=> ({byte_q[0], byte_q[1]} == $past(wr_data)));
endmodule

// File: rtl/xfer_seq.sv
module xfer_seq
    import xfer_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int SEL_W  = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic                op_exg,
    input  logic [2*SEL_W-1:0]  postbyte,
    input  logic [WORD_W-1:0]   rd_data,
    output logic [SEL_W-1:0]    rd_sel,
    output logic                wr_en,
    output logic [SEL_W-1:0]    wr_sel,
    output logic [WORD_W-1:0]   wr_data,
    output logic                busy,
    output logic                done
);
    seq_state_t state_q, state_d;
    logic              exg_q;
    logic [SEL_W-1:0]  src_q, dst_q;
    logic [WORD_W-1:0] temp_q;
    logic              accept;

    assign accept = start && (state_q == S_IDLE || state_q == S_FIN);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE, S_FIN: state_d = start ? S_OPC : S_IDLE;
            S_OPC:         state_d = S_PBY;
            S_PBY:         state_d = S_P1A;
            S_P1A:         state_d = S_P1B;
            S_P1B:         state_d = S_P2A;
            S_P2A:         state_d = S_P2B;
            S_P2B:         state_d = exg_q ? S_P3A : S_FIN;
            S_P3A:         state_d = S_P3B;
            S_P3B:         state_d = S_FIN;
            default:       state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= S_IDLE;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            exg_q  <= 1'b0;
            src_q  <= '0;
            dst_q  <= '0;
            temp_q <= '0;
        end else begin
            if (accept) begin
                exg_q <= op_exg;
                src_q <= postbyte[2*SEL_W-1:SEL_W];
                dst_q <= postbyte[SEL_W-1:0];
            end
            if (state_q == S_P1B) temp_q <= rd_data;
        end
    end

    always_comb begin
        busy    = 1'b0;
        done    = 1'b0;
        rd_sel  = src_q;
        wr_en   = 1'b0;
        wr_sel  = dst_q;
        wr_data = temp_q;
        unique case (state_q)
            S_IDLE: ;
            S_FIN:  done = 1'b1;
            S_OPC, S_PBY, S_P1A, S_P1B, S_P3A: busy = 1'b1;
            S_P2A: begin
                busy = 1'b1;
                if (exg_q) rd_sel = dst_q;
            end
            S_P2B: begin
                busy  = 1'b1;
                wr_en = 1'b1;
                if (exg_q) begin
                    rd_sel  = dst_q;
                    wr_sel  = src_q;
                    wr_data = rd_data;
                end
            end
            S_P3B: begin
                busy  = 1'b1;
                wr_en = 1'b1;
            end
            default: ;
        endcase
    end

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);
    // R9
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (rst) !(busy && done));
    // R3
    done_after_write_chk: assert property (@(posedge clk) disable iff (rst) $rose(done) |-> $past(wr_en));
    // R8
    ignore_start_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> ($stable(src_q) && $stable(dst_q) && $stable(exg_q)));
    // R4
    temp_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_P2A) |=> $stable(temp_q));
endmodule

// File: rtl/xfer_exchange_unit.sv
module xfer_exchange_unit
    import xfer_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic        op_exg,
    input  logic [7:0]  postbyte,
    output logic        busy,
    output logic        done,
    output logic [7:0]  reg_a,
    output logic [7:0]  reg_b,
    output logic [15:0] reg_x,
    output logic [15:0] reg_y,
    output logic [15:0] reg_u,
    output logic [15:0] reg_s,
    output logic [15:0] reg_pc,
    output logic [7:0]  reg_cc,
    output logic [7:0]  reg_dp
);
    localparam int NUM_WIDE = 5;
    localparam int NUM_BYTE = 4;

    logic [SEL_W-1:0]  rd_sel, wr_sel;
    logic [WORD_W-1:0] rd_data, wr_data;
    logic              wr_en;
    logic [WORD_W-1:0] wide_q [NUM_WIDE];
    logic [BYTE_W-1:0] byte_q [NUM_BYTE];

    xfer_seq #(.WORD_W(WORD_W), .SEL_W(SEL_W)) u_seq (
        .clk(clk), .rst(rst), .start(start), .op_exg(op_exg), .postbyte(postbyte),
        .rd_data(rd_data), .rd_sel(rd_sel), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .busy(busy), .done(done)
    );

    xfer_regfile #(.WORD_W(WORD_W), .BYTE_W(BYTE_W), .SEL_W(SEL_W),
                   .NUM_WIDE(NUM_WIDE), .NUM_BYTE(NUM_BYTE), .BYTE_BASE(8)) u_rf (
        .clk(clk), .rst(rst), .rd_sel(rd_sel), .rd_data(rd_data),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .wide_q(wide_q), .byte_q(byte_q)
    );

    assign reg_a  = byte_q[0];
    assign reg_b  = byte_q[1];
    assign reg_cc = byte_q[2];
    assign reg_dp = byte_q[3];
    assign reg_x  = wide_q[0];
    assign reg_y  = wide_q[1];
    assign reg_u  = wide_q[2];
    assign reg_s  = wide_q[3];
    assign reg_pc = wide_q[4];
endmodule

// File: tb/test_xfer_exchange_unit.sv
`timescale 1ns/1ps
module test_xfer_exchange_unit;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic op_exg = 1'b0;
    logic [7:0] postbyte = 8'h00;
    logic busy, done;
    logic [7:0]  reg_a, reg_b, reg_cc, reg_dp;
    logic [15:0] reg_x, reg_y, reg_u, reg_s, reg_pc;

    xfer_exchange_unit i_xfer_exchange_unit (
        .clk(clk), .rst(rst), .start(start), .op_exg(op_exg), .postbyte(postbyte),
        .busy(busy), .done(done), .reg_a(reg_a), .reg_b(reg_b), .reg_x(reg_x),
        .reg_y(reg_y), .reg_u(reg_u), .reg_s(reg_s), .reg_pc(reg_pc),
        .reg_cc(reg_cc), .reg_dp(reg_dp)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    always @(posedge clk) cyc++;

    // reference register model
    logic [7:0]  ma, mb, mcc, mdp;
    logic [15:0] mw [5];
    logic [111:0] q_regs [$];
    int           q_due  [$];
    string        q_tag  [$];

    task automatic chk(input bit ok, input string req, input logic [111:0] act, input logic [111:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] m_read(input logic [3:0] c);
        if (c == 4'd0) return {ma, mb};
        if (c >= 4'd1 && c <= 4'd5) return mw[c - 4'd1];
        if (c == 4'd8) return {8'hFF, ma};
        if (c == 4'd9) return {8'hFF, mb};
        if (c == 4'd10) return {8'hFF, mcc};
        if (c == 4'd11) return {8'hFF, mdp};
        return 16'hFFFF;
    endfunction

    task automatic m_write(input logic [3:0] c, input logic [15:0] v);
        if (c == 4'd0) begin ma = v[15:8]; mb = v[7:0]; end
        else if (c >= 4'd1 && c <= 4'd5) mw[c - 4'd1] = v;
        else if (c == 4'd8) ma = v[7:0];
        else if (c == 4'd9) mb = v[7:0];
        else if (c == 4'd10) mcc = v[7:0];
        else if (c == 4'd11) mdp = v[7:0];
    endtask

    function automatic logic [111:0] m_snap();
        return {ma, mb, mw[0], mw[1], mw[2], mw[3], mw[4], mcc, mdp};
    endfunction

    function automatic logic [111:0] dut_snap();
        return {reg_a, reg_b, reg_x, reg_y, reg_u, reg_s, reg_pc, reg_cc, reg_dp};
    endfunction

    // driver: model the operation, push expectation, drive and watch busy/done
    task automatic run_op(input bit exg, input logic [7:0] pb, input bit stray,
                          input bit chain, input string tag);
        int lat;
        logic [15:0] t;
        if (!chain) @(negedge clk);
        lat = exg ? 9 : 7;
        if (exg) begin
            t = m_read(pb[7:4]);
            m_write(pb[7:4], m_read(pb[3:0]));
            m_write(pb[3:0], t);
        end else begin
            m_write(pb[3:0], m_read(pb[7:4]));
        end
        q_regs.push_back(m_snap());
        q_due.push_back(cyc + lat);
        q_tag.push_back(tag);
        start = 1'b1;
        op_exg = exg;
        postbyte = pb;
        for (int i = 1; i <= lat; i++) begin
            @(negedge clk);
            start = 1'b0;
            if (stray && i == 3) begin
                start = 1'b1;      // R8: would set S to 0xFFFF if obeyed
                op_exg = 1'b0;
                postbyte = 8'h64;
            end
            chk(busy == (i < lat), exg ? "R4 busy" : "R3 busy", {111'd0, busy}, {111'd0, (i < lat)});
            chk(done == (i == lat), "R9 done", {111'd0, done}, {111'd0, (i == lat)});
        end
    endtask

    // monitor: compare registers and timing whenever done is seen
    always @(negedge clk) begin
        if (!rst && done) begin
            if (q_regs.size() == 0) begin
                chk(1'b0, "R8/R9 unexpected done", 112'd1, 112'd0);
            end else begin
                logic [111:0] er;
                int ed;
                string et;
                er = q_regs.pop_front();
                ed = q_due.pop_front();
                et = q_tag.pop_front();
                chk(dut_snap() == er, et, dut_snap(), er);
                chk(cyc == ed, {et, " timing"}, 112'(cyc), 112'(ed));
            end
        end
    end

    initial begin
        #2000000;
        chk(1'b0, "watchdog", 112'd0, 112'd1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        ma = 0; mb = 0; mcc = 0; mdp = 0;
        for (int k = 0; k < 5; k++) mw[k] = 16'h0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(dut_snap() == 112'd0, "R1 regs", dut_snap(), 112'd0);
        chk(!busy && !done, "R1 flags", {110'd0, busy, done}, 112'd0);

        run_op(0, 8'h68, 0, 0, "R7 invalid source into A");       // A = FF
        run_op(0, 8'h91, 0, 0, "R5 byte B into X");                // X = FF00
        run_op(0, 8'h10, 0, 0, "R6 X into D");
        run_op(0, 8'h02, 0, 0, "R6 D into Y");
        run_op(1, 8'h89, 0, 0, "R5 swap A,B");
        run_op(0, 8'h03, 0, 0, "R2 D into U");
        run_op(1, 8'h13, 0, 0, "R4 swap X,U");
        run_op(0, 8'h17, 0, 0, "R7 write to invalid code");
        run_op(1, 8'h08, 0, 0, "R10 swap D,A overlap");
        run_op(0, 8'h25, 1, 0, "R8 stray start during busy");
        run_op(0, 8'h6B, 0, 0, "R2 invalid into DP");
        run_op(1, 8'hB4, 0, 1, "R9 chained swap DP,S");
        run_op(1, 8'h52, 0, 1, "R4 chained swap PC,Y");
        run_op(0, 8'hAB, 0, 0, "R5 CC into DP");

        repeat (4) @(negedge clk);
        chk(q_regs.size() == 0, "R9 pending results", 112'(q_regs.size()), 112'd0);
        chk(!busy && !done, "R3 idle at end", {110'd0, busy, done}, 112'd0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule